// File: doc/BRIEF.md
# Serial Programmer Host Sequencer

This block is the host side of a four-wire in-system programming link to a small microcontroller target. It drives the target's reset line, a serial clock and a serial data line toward the target, and it reads the target's serial response. Out of its own reset it runs the power-up and entry sequence without help. That sequence holds the target in reset with the clock low, gives reset a short positive pulse, waits the settling time and sends the programming-enable instruction. If the target does not echo, the block slips the bit framing by one extra clock pulse and tries again, up to an attempt limit.

Once the target is in programming mode, the block takes one request at a time: chip erase, byte write (flash or EEPROM), byte read, or end of session. Every instruction is a 32-bit frame sent most significant bit first. Completion is timed with fixed waits counted in system clock cycles, and the target's busy status is never polled. A chip erase is followed by a reset pulse and a full re-entry. Ending the session releases the target by driving its reset high.

Top module: `sprog_host`

## Requirements
- R1: After `rst_n` is released, `tgt_rst` and `tgt_sck` stay low for `RST_PULSE` cycles. `tgt_rst` is then high for `RST_PULSE` cycles and then returns low.
- R2: No rising edge of `tgt_sck` occurs sooner than `ENTRY_WAIT` cycles after `tgt_rst` falls at the end of a reset pulse.
- R3: Every frame has 32 clock pulses. Each high and low phase lasts `SCK_HALF` cycles. `tgt_mosi` carries bits MSB first and changes only while `tgt_sck` is low. `tgt_miso` is sampled when `tgt_sck` falls.
- R4: The programming-enable frame is 0xAC,0x53,0x00,0x00. Entry succeeds when the byte received during the third byte is 0x53. All four bytes are always sent. On success, `req_ready` rises.
- R5: After a failed echo, one extra single `tgt_sck` pulse follows and then a new enable frame. After `MAX_TRY` failed attempts, `no_dev` goes high and stays high, the serial clock stops, and `req_ready` stays low.
- R6: Erase (`req_op`=0) sends 0xAC,0x80,0x00,0x00 and waits `ERASE_WAIT` cycles. It then repeats the reset pulse, the entry wait and the enable handshake. `done` follows the successful re-entry.
- R7: Write (`req_op`=1) sends the first byte 0x40 for flash (`req_mem`=0) or 0xC0 for EEPROM (`req_mem`=1), then the address high byte, the address low byte and the data. `done` comes no sooner than `FLASH_WAIT` or `EEPROM_WAIT` cycles after the last falling clock edge.
- R8: A flash write of 0xFF after an erase in the same session sends no frame and raises `done` within three cycles. An EEPROM write of 0xFF is always sent.
- R9: Read (`req_op`=2) sends the first byte 0x20 for flash or 0xA0 for EEPROM, then the address high byte, the address low byte and 0x00. `rdata` holds the byte received during the fourth byte and is valid when `done` is high.
- R10: End (`req_op`=3) drives `tgt_rst` high and keeps it high. It gives one `done` pulse, after which `req_ready` stays low and `tgt_sck` stays idle.
- R11: A request is taken only while `req_ready` is high. `req_valid` at any other time has no effect.
- R12: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 erase, 1 write, 2 read, 3 end |
| req_mem | input | 1 | 0 flash, 1 EEPROM |
| req_addr | input | AW | Byte address |
| req_data | input | 8 | Write data |
| req_ready | output | 1 | Idle in programming mode, request accepted |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| no_dev | output | 1 | Entry handshake exhausted its attempts |
| tgt_rst | output | 1 | Level on the target reset line |
| tgt_sck | output | 1 | Serial clock to the target |
| tgt_mosi | output | 1 | Serial data to the target |
| tgt_miso | input | 1 | Serial data from the target |

## Verification
If the bit or attempt counter holds a wrong value, the fault appears at the ports within one frame. A frame then carries the wrong number of clock pulses, or the enable retries stop at the wrong count, and a model target that counts pulses sees this at the next instruction boundary. A wrong wait-timer value or a wrong sequencer state shows up as `done` too early relative to the last clock fall, as a missing reset pulse after erase, or as read data that does not match what the model target stored. The framing-slip retry is checked by starting the model target three bits out of step and counting the clock pulses needed before `req_ready` rises.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_END   = 2'd3
  } sprog_op_e;

  localparam logic [7:0] BYTE_PREFIX = 8'hAC;
  localparam logic [7:0] BYTE_ENTER  = 8'h53;
  localparam logic [7:0] BYTE_ERASE  = 8'h80;
  localparam logic [7:0] BYTE_WR_FL  = 8'h40;
  localparam logic [7:0] BYTE_WR_EE  = 8'hC0;
  localparam logic [7:0] BYTE_RD_FL  = 8'h20;
  localparam logic [7:0] BYTE_RD_EE  = 8'hA0;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_RPULSE,
    ST_SETTLE,
    ST_EN_RUN,
    ST_SYNC_RUN,
    ST_IDLE,
    ST_CMD_RUN,
    ST_PROG_WAIT,
    ST_ERASE_WAIT,
    ST_DONE,
    ST_FIN,
    ST_OFF,
    ST_NODEV
  } sprog_st_e;

  function automatic logic [31:0] make_frame(input logic [7:0] b0,
                                             input logic [15:0] adr,
                                             input logic [7:0] dat);
    return {b0, adr, dat};
  endfunction

endpackage

// File: rtl/sprog_phase.sv
module sprog_phase #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == CW'(HALF - 1));
    cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sprog_shift.sv
module sprog_shift #(
  parameter int unsigned HALF = 4,
  parameter int unsigned FW   = 32,
  parameter int unsigned RXW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           pulse_only,
  input  logic [FW-1:0]  tx_word,
  input  logic           miso,
  output logic           sck,
  output logic           mosi,
  output logic           fin,
  output logic [RXW-1:0] rx_word
);
  localparam int unsigned BCW = $clog2(FW + 1);

  logic           run_q, run_d;
  logic           sck_q, sck_d;
  logic           fin_q, fin_d;
  logic [FW-1:0]  tx_q, tx_d;
  logic [RXW-1:0] rx_q, rx_d;
  logic [BCW-1:0] left_q, left_d;
  logic           tick;

  sprog_phase #(.HALF(HALF)) u_phase (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run_q),
    .tick (tick)
  );

  always_comb begin
    run_d  = run_q;
    sck_d  = sck_q;
    fin_d  = 1'b0;
    tx_d   = tx_q;
    rx_d   = rx_q;
    left_d = left_q;
    if (go && !run_q) begin
      run_d  = 1'b1;
      sck_d  = 1'b0;
      tx_d   = pulse_only ? '0 : tx_word;
      left_d = pulse_only ? BCW'(1) : BCW'(FW);
    end else if (tick) begin
      if (!sck_q) begin
        sck_d = 1'b1;
      end else begin
        sck_d  = 1'b0;
        rx_d   = {rx_q[RXW-2:0], miso};
        tx_d   = {tx_q[FW-2:0], 1'b0};
        left_d = left_q - 1'b1;
        if (left_q == BCW'(1)) begin
          run_d = 1'b0;
          fin_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sck_q  <= 1'b0;
      fin_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      left_q <= '0;
    end else begin
      run_q  <= run_d;
      sck_q  <= sck_d;
      fin_q  <= fin_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      left_q <= left_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = tx_q[FW-1];
  assign fin     = fin_q;
  assign rx_word = rx_q;

  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(tx_q[FW-1]));

  // R3
  fin_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (!sck_q && $past(sck_q)));
endmodule

// File: rtl/sprog_timer.sv
module sprog_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic [W-1:0] rst_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)             cnt_d = val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= rst_val;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R7
  rest_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/sprog_host.sv
module sprog_host #(
  parameter int unsigned SCK_HALF    = 250,
  parameter int unsigned RST_PULSE   = 150,
  parameter int unsigned ENTRY_WAIT  = 1000000,
  parameter int unsigned ERASE_WAIT  = 500000,
  parameter int unsigned FLASH_WAIT  = 225000,
  parameter int unsigned EEPROM_WAIT = 450000,
  parameter int unsigned MAX_TRY     = 32,
  parameter int unsigned AW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          req_mem,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          req_ready,
  output logic          done,
  output logic [7:0]    rdata,
  output logic          no_dev,
  output logic          tgt_rst,
  output logic          tgt_sck,
  output logic          tgt_mosi,
  input  logic          tgt_miso
);
  import sprog_pkg::*;

  localparam int unsigned M1 = (RST_PULSE > ENTRY_WAIT) ? RST_PULSE : ENTRY_WAIT;
  localparam int unsigned M2 = (ERASE_WAIT > FLASH_WAIT) ? ERASE_WAIT : FLASH_WAIT;
  localparam int unsigned M3 = (M1 > M2) ? M1 : M2;
  localparam int unsigned WAIT_MAX = (M3 > EEPROM_WAIT) ? M3 : EEPROM_WAIT;
  localparam int unsigned TW  = $clog2(WAIT_MAX + 1);
  localparam int unsigned ACW = $clog2(MAX_TRY + 1);
  localparam logic [31:0] FRAME_ENTER = {BYTE_PREFIX, BYTE_ENTER, 16'h0000};
  localparam logic [31:0] FRAME_ERASE = {BYTE_PREFIX, BYTE_ERASE, 16'h0000};

  sprog_st_e      st_q, st_d;
  sprog_op_e      cmd_q, cmd_d;
  logic           mem_q, mem_d;
  logic [ACW-1:0] att_q, att_d;
  logic           erased_q, erased_d;
  logic           reent_q, reent_d;
  logic [7:0]     rdata_q, rdata_d;

  logic           go, pulse_only, fin;
  logic [31:0]    tx_word;
  logic [15:0]    rx_word;
  logic           tmr_load, tmr_zero;
  logic [TW-1:0]  tmr_val;
  logic [15:0]    adr16;
  logic           skip_ff;

  assign adr16   = 16'(req_addr);
  assign skip_ff = !req_mem && (req_data == 8'hFF) && erased_q;

  sprog_shift #(.HALF(SCK_HALF), .FW(32), .RXW(16)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .pulse_only(pulse_only),
    .tx_word   (tx_word),
    .miso      (tgt_miso),
    .sck       (tgt_sck),
    .mosi      (tgt_mosi),
    .fin       (fin),
    .rx_word   (rx_word)
  );

  sprog_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .val    (tmr_val),
    .rst_val(TW'(RST_PULSE)),
    .zero   (tmr_zero)
  );

  always_comb begin
    st_d       = st_q;
    cmd_d      = cmd_q;
    mem_d      = mem_q;
    att_d      = att_q;
    erased_d   = erased_q;
    reent_d    = reent_q;
    rdata_d    = rdata_q;
    go         = 1'b0;
    pulse_only = 1'b0;
    tx_word    = FRAME_ENTER;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    unique case (st_q)
      ST_HOLD: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(RST_PULSE);
        st_d     = ST_RPULSE;
      end
      ST_RPULSE: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(ENTRY_WAIT);
        st_d     = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_zero) begin
        go      = 1'b1;
        tx_word = FRAME_ENTER;
        st_d    = ST_EN_RUN;
      end
      ST_EN_RUN: if (fin) begin
        if (rx_word[15:8] == BYTE_ENTER) begin
          att_d   = '0;
          reent_d = 1'b0;
          st_d    = reent_q ? ST_DONE : ST_IDLE;
        end else if (att_q == ACW'(MAX_TRY - 1)) begin
          st_d = ST_NODEV;
        end else begin
          att_d      = att_q + 1'b1;
          go         = 1'b1;
          pulse_only = 1'b1;
          st_d       = ST_SYNC_RUN;
        end
      end
      ST_SYNC_RUN: if (fin) begin
        go      = 1'b1;
        tx_word = FRAME_ENTER;
        st_d    = ST_EN_RUN;
      end
      ST_IDLE: if (req_valid) begin
        cmd_d = sprog_op_e'(req_op);
        mem_d = req_mem;
        unique case (sprog_op_e'(req_op))
          OP_ERASE: begin
            go      = 1'b1;
            tx_word = FRAME_ERASE;
            st_d    = ST_CMD_RUN;
          end
          OP_WRITE: begin
            if (skip_ff) begin
              st_d = ST_DONE;
            end else begin
              go      = 1'b1;
              tx_word = make_frame(req_mem ? BYTE_WR_EE : BYTE_WR_FL, adr16, req_data);
              st_d    = ST_CMD_RUN;
            end
          end
          OP_READ: begin
            go      = 1'b1;
            tx_word = make_frame(req_mem ? BYTE_RD_EE : BYTE_RD_FL, adr16, 8'h00);
            st_d    = ST_CMD_RUN;
          end
          default: st_d = ST_FIN;
        endcase
      end
      ST_CMD_RUN: if (fin) begin
        unique case (cmd_q)
          OP_ERASE: begin
            erased_d = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = TW'(ERASE_WAIT);
            st_d     = ST_ERASE_WAIT;
          end
          OP_WRITE: begin
            tmr_load = 1'b1;
            tmr_val  = mem_q ? TW'(EEPROM_WAIT) : TW'(FLASH_WAIT);
            st_d     = ST_PROG_WAIT;
          end
          default: begin
            rdata_d = rx_word[7:0];
            st_d    = ST_DONE;
          end
        endcase
      end
      ST_PROG_WAIT: if (tmr_zero) st_d = ST_DONE;
      ST_ERASE_WAIT: if (tmr_zero) begin
        reent_d  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(RST_PULSE);
        st_d     = ST_RPULSE;
      end
      ST_DONE: st_d = ST_IDLE;
      ST_FIN:  st_d = ST_OFF;
      ST_OFF:  st_d = ST_OFF;
      default: st_d = ST_NODEV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_HOLD;
      cmd_q    <= OP_ERASE;
      mem_q    <= 1'b0;
      att_q    <= '0;
      erased_q <= 1'b0;
      reent_q  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      st_q     <= st_d;
      cmd_q    <= cmd_d;
      mem_q    <= mem_d;
      att_q    <= att_d;
      erased_q <= erased_d;
      reent_q  <= reent_d;
      rdata_q  <= rdata_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign done      = (st_q == ST_DONE) || (st_q == ST_FIN);
  assign no_dev    = (st_q == ST_NODEV);
  assign tgt_rst   = (st_q == ST_RPULSE) || (st_q == ST_FIN) || (st_q == ST_OFF);
  assign rdata     = rdata_q;

  // R5
  nodev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_dev |=> (no_dev && !tgt_sck && !req_ready));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!tgt_sck && !tgt_rst));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  released_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_rst && !req_ready && $past(done)) |=> tgt_rst);
endmodule

// File: tb/sprog_host_bench.sv
module sprog_host_bench;
  localparam int unsigned SCK_HALF = 2;
  localparam int unsigned RST_P    = 4;
  localparam int unsigned ENTRY_W  = 40;
  localparam int unsigned ERASE_W  = 60;
  localparam int unsigned FL_W     = 20;
  localparam int unsigned EE_W     = 30;
  localparam int unsigned TRIES    = 32;

  typedef struct packed {
    logic [1:0] op;
    logic       mem;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd1, 1'b0, 8'h10, 8'h5A, 8'h00},
    '{2'd1, 1'b1, 8'h10, 8'hA5, 8'h00},
    '{2'd2, 1'b0, 8'h10, 8'h00, 8'h5A},
    '{2'd2, 1'b1, 8'h10, 8'h00, 8'hA5},
    '{2'd1, 1'b0, 8'h22, 8'h00, 8'h00},
    '{2'd1, 1'b0, 8'h23, 8'hFF, 8'h00},
    '{2'd2, 1'b0, 8'h23, 8'h00, 8'hFF},
    '{2'd2, 1'b0, 8'h22, 8'h00, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic        req_mem = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_data = 8'h0;
  logic        req_ready, done, no_dev, tgt_rst, tgt_sck, tgt_mosi, tgt_miso;
  logic [7:0]  rdata;

  sprog_host #(
    .SCK_HALF(SCK_HALF), .RST_PULSE(RST_P), .ENTRY_WAIT(ENTRY_W),
    .ERASE_WAIT(ERASE_W), .FLASH_WAIT(FL_W), .EEPROM_WAIT(EE_W),
    .MAX_TRY(TRIES), .AW(16)
  ) u_sprog_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_mem(req_mem), .req_addr(req_addr), .req_data(req_data),
    .req_ready(req_ready), .done(done), .rdata(rdata), .no_dev(no_dev),
    .tgt_rst(tgt_rst), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_miso(tgt_miso)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int rises = 0;
  int rst_rises = 0;
  int done_cnt = 0;
  int fall_cyc = 0;
  int hi_start = 0;
  int hi_min = 1000;
  int rst_up_cyc = 0;
  int rst_dn_cyc = 0;
  int first_rise_cyc = -1;
  bit finished = 1'b0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (done) done_cnt = done_cnt + 1;
  end

  // behavioural target
  bit          present = 1'b1;
  int          t_offset = 0;
  int          t_nb = 0;
  logic [31:0] t_sh = '0;
  logic [31:0] t_last = '0;
  logic [7:0]  t_out = '0;
  logic [7:0]  fmem [256];
  logic [7:0]  emem [256];

  assign tgt_miso = present && t_out[~t_nb[2:0]];

  initial begin
    for (int i = 0; i < 256; i++) begin
      fmem[i] = 8'h00;
      emem[i] = 8'h00;
    end
  end

  always @(posedge tgt_rst) begin
    rst_rises = rst_rises + 1;
    rst_up_cyc = cyc;
    t_nb = t_offset;
    t_sh = '0;
    t_out = '0;
  end

  always @(negedge tgt_rst) rst_dn_cyc = cyc;

  always @(posedge tgt_sck) begin
    t_sh = {t_sh[30:0], tgt_mosi};
    rises = rises + 1;
    hi_start = cyc;
    if (first_rise_cyc < 0) first_rise_cyc = cyc;
  end

  always @(negedge tgt_sck) begin
    fall_cyc = cyc;
    if (cyc - hi_start < hi_min) hi_min = cyc - hi_start;
    t_nb = t_nb + 1;
    if (t_nb[2:0] == 3'd0) begin
      t_out = 8'h00;
      case (t_nb[4:3])
        2'd2: if (t_sh[15:8] == 8'hAC) t_out = t_sh[7:0];
        2'd3: begin
          if (t_sh[23:16] == 8'h20) t_out = fmem[t_sh[7:0]];
          if (t_sh[23:16] == 8'hA0) t_out = emem[t_sh[7:0]];
        end
        2'd0: begin
          t_last = t_sh;
          if (t_sh[31:24] == 8'h40) fmem[t_sh[15:8]] = t_sh[7:0];
          if (t_sh[31:24] == 8'hC0) emem[t_sh[15:8]] = t_sh[7:0];
          if (t_sh[31:16] == 16'hAC80) begin
            for (int i = 0; i < 256; i++) begin
              fmem[i] = 8'hFF;
              emem[i] = 8'hFF;
            end
          end
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  logic [7:0] got_rd;
  int         got_lat;
  int         got_wait;

  task automatic do_req(input logic [1:0] op, input logic mem,
                        input logic [7:0] a, input logic [7:0] d, input bit poke);
    int n = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_mem = mem;
    req_addr = {8'h00, a}; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_valid = 1'b1; req_op = 2'd3;
      repeat (10) @(negedge clk);
      req_valid = 1'b0;
      n = 10;
    end
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    got_wait = n;
    got_rd = rdata;
    got_lat = cyc - fall_cyc;
    @(negedge clk);
    chk(!done, "R12", "done width", done, 0);
  endtask

  initial begin
    int r0, d0, r1;
    logic [7:0] b0;
    t_offset = 29;
    repeat (3) @(negedge clk);
    chk(!tgt_rst && !tgt_sck && !req_ready && !done && !no_dev, "R1", "reset outputs",
        {tgt_rst, tgt_sck, req_ready, done, no_dev}, 0);
    rises = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (!req_ready) @(negedge clk);
    chk((rst_dn_cyc - rst_up_cyc) >= RST_P && (rst_dn_cyc - rst_up_cyc) <= RST_P + 2,
        "R1", "reset pulse width", rst_dn_cyc - rst_up_cyc, RST_P);
    chk(first_rise_cyc - rst_dn_cyc >= ENTRY_W, "R2", "entry wait",
        first_rise_cyc - rst_dn_cyc, ENTRY_W);
    chk(rises == 4 * 32 + 3, "R5", "slip retries before sync", rises, 4 * 32 + 3);
    chk(t_last == 32'hAC530000, "R4", "enable frame", t_last, 32'hAC530000);
    chk(hi_min >= SCK_HALF, "R3", "clock high phase", hi_min, SCK_HALF);
    t_offset = 0;

    foreach (VEC[k]) begin
      r0 = rises;
      do_req(VEC[k].op, VEC[k].mem, VEC[k].addr, VEC[k].data, 1'b0);
      chk(rises - r0 == 32, "R3", "pulses per frame", rises - r0, 32);
      if (VEC[k].op == 2'd1) begin
        b0 = VEC[k].mem ? 8'hC0 : 8'h40;
        chk(t_last == {b0, 8'h00, VEC[k].addr, VEC[k].data}, "R7", "write frame",
            t_last, {b0, 8'h00, VEC[k].addr, VEC[k].data});
        chk(got_lat >= (VEC[k].mem ? EE_W : FL_W), "R7", "write wait",
            got_lat, VEC[k].mem ? EE_W : FL_W);
      end else begin
        b0 = VEC[k].mem ? 8'hA0 : 8'h20;
        chk(t_last == {b0, 8'h00, VEC[k].addr, 8'h00}, "R9", "read frame",
            t_last, {b0, 8'h00, VEC[k].addr, 8'h00});
        chk(got_rd == VEC[k].exp, "R9", "read data", got_rd, VEC[k].exp);
      end
    end

    // erase with re-entry
    r0 = rises; r1 = rst_rises;
    do_req(2'd0, 1'b0, 8'h00, 8'h00, 1'b0);
    chk(rises - r0 == 64, "R6", "erase plus enable pulses", rises - r0, 64);
    chk(rst_rises - r1 == 1, "R6", "reset pulse after erase", rst_rises - r1, 1);
    chk(got_lat >= 0 && t_last == 32'hAC530000, "R6", "re-entry frame", t_last, 32'hAC530000);
    do_req(2'd2, 1'b0, 8'h10, 8'h00, 1'b0);
    chk(got_rd == 8'hFF, "R6", "flash erased", got_rd, 8'hFF);

    // skipped flash 0xFF, sent EEPROM 0xFF
    r0 = rises;
    do_req(2'd1, 1'b0, 8'h30, 8'hFF, 1'b0);
    chk(rises == r0, "R8", "flash FF skipped", rises - r0, 0);
    chk(got_wait <= 2, "R8", "skip latency", got_wait, 2);
    do_req(2'd1, 1'b1, 8'h31, 8'hFF, 1'b0);
    chk(rises - r0 == 32 && t_last == 32'hC00031FF, "R8", "eeprom FF sent", t_last, 32'hC00031FF);

    // request while busy
    r0 = rises; d0 = done_cnt;
    do_req(2'd1, 1'b0, 8'h40, 8'h12, 1'b1);
    repeat (5) @(negedge clk);
    chk(rises - r0 == 32, "R11", "busy request ignored frames", rises - r0, 32);
    chk(!tgt_rst && req_ready, "R11", "busy end ignored", {tgt_rst, req_ready}, 1);
    chk(done_cnt - d0 == 1, "R12", "one done per request", done_cnt - d0, 1);

    // end of session
    r0 = rises;
    do_req(2'd3, 1'b0, 8'h00, 8'h00, 1'b0);
    repeat (50) @(negedge clk);
    chk(tgt_rst && !req_ready && rises == r0, "R10", "released",
        {tgt_rst, req_ready, 8'(rises - r0)}, 3'b100);

    // no device
    rst_n = 1'b0; present = 1'b0;
    repeat (3) @(negedge clk);
    rises = 0;
    rst_n = 1'b1;
    while (!no_dev && cyc < 150000) @(negedge clk);
    chk(rises == TRIES * 32 + TRIES - 1, "R5", "attempts before giving up",
        rises, TRIES * 32 + TRIES - 1);
    r0 = rises;
    repeat (40) @(negedge clk);
    chk(no_dev && !req_ready && rises == r0, "R5", "no device sticky",
        {no_dev, req_ready}, 2'b10);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule